// File: doc/BRIEF.md
# Sprite Attribute Block Copy Engine

This engine copies a fixed-length run of bytes (160 by default) from a page anywhere in the 16-bit CPU address space into the sprite attribute RAM. Software starts a copy by presenting a base address on the trigger inputs for one cycle. After a fixed start latency the engine fetches one byte per pacing interval through the system read port. It writes each byte into the attribute RAM at an offset that counts up from zero.

The read port is combinational. In the cycle that `rd_req` is high, the external fabric returns `rd_data` for `rd_addr`, and the same value is written to the attribute RAM at the clock edge that ends that cycle. Because the fetch uses the ordinary bus path, the usual region decoding applies to it. While a copy is running the engine exports `busy` and its current source pointer. The address decoder outside uses these two signals to block CPU accesses that would collide with the copy. A new valid trigger abandons any copy in flight and starts again from the new base.

Top module: `sprite_dma`

## Requirements
- R1: A synchronous active-high reset clears the engine. After reset `busy`, `done`, `rd_req` and `attr_we` are 0 and `src_addr` is 0x0000.
- R2: On a clock edge where `trig_valid` is 1 and `trig_base` is at most 0xF100, the engine accepts the trigger. After that edge `busy` is 1, `src_addr` equals the base, and the next write goes to offset 0.
- R3: A trigger whose base is greater than 0xF100 (for example 0xF101 or 0xFFFF) has no effect. The engine stays idle, or a running copy continues unchanged, and `src_addr` does not jump. A base of exactly 0xF100 is accepted.
- R4: The first byte is committed on the 8th rising edge after the edge that accepts the trigger. `rd_req` and `attr_we` are high during the cycle that this edge ends, and low in the cycles before it.
- R5: Each later byte is committed 4 rising edges after the previous one, and the strobes are low in between.
- R6: For the byte with index i (0-based), `rd_addr` is base+i (modulo 2^16), `attr_addr` is i, and `attr_wdata` equals `rd_data`. `src_addr` always shows base plus the number of bytes already committed.
- R7: A copy commits exactly 160 bytes. `busy` falls after the commit edge of the last byte.
- R8: `done` is high for exactly one cycle, the cycle right after the last byte's commit edge, and it is never high together with `busy`.
- R9: A valid trigger accepted while a copy is running restarts it. Offset returns to 0, the source is reloaded, and the first byte of the new copy again waits the full 8-edge start latency. The abandoned copy produces no `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_valid | input | 1 | Trigger strobe, sampled each rising edge |
| trig_base | input | 16 | Source base address of the trigger |
| rd_req | output | 1 | Read request on the system bus for this cycle |
| rd_addr | output | 16 | Bus read address |
| rd_data | input | 8 | Bus read data, valid in the cycle of `rd_req` |
| attr_we | output | 1 | Attribute RAM write enable |
| attr_addr | output | 8 | Attribute RAM byte offset |
| attr_wdata | output | 8 | Attribute RAM write data |
| busy | output | 1 | Copy in progress, used for contention blocking |
| src_addr | output | 16 | Current source pointer, used for contention blocking |
| done | output | 1 | One-cycle pulse after the final byte |

## Verification
The hardest situation to reach is a restart whose trigger edge falls exactly on a byte commit edge, or just before one. In those cases the old schedule and the new latency overlap. The stimulus produces these cases by starting a copy and then issuing a second trigger after a range of different delays, stepping the delay one cycle at a time so that every phase of the 4-cycle pacing is hit, including the commit edge itself. A behavioural model with its own schedule arithmetic predicts every strobe, address and `done` in every cycle. Boundary bases on either side of the limit are issued both while the engine is idle and while it is busy.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    // Architectural width of the CPU address space
    localparam int ADDR_W = 16;

    // Decoded trigger: accepted flag plus the base it carries
    typedef struct packed {
        logic              go;
        logic [ADDR_W-1:0] base;
    } sdma_cmd_t;

    // Bits needed to hold values 0 .. n-1, at least one
    function automatic int span_bits(input int n);
        int b;
        b = $clog2(n);
        return (b < 1) ? 1 : b;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdma_trig_decode.sv
module sdma_trig_decode
    import sdma_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_LIMIT = 16'hF100
) (
    input  logic              trig_valid,
    input  logic [ADDR_W-1:0] trig_base,
    output sdma_cmd_t         cmd
);

    always_comb begin
        cmd.base = trig_base;
        cmd.go   = trig_valid && (trig_base <= BASE_LIMIT);
    end

endmodule

// File: rtl/sdma_pacer.sv
module sdma_pacer
    import sdma_pkg::*;
#(
    parameter int LEAD_CYCLES = 8,
    parameter int PACE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic fire
);

    localparam int TW = span_bits(max2(LEAD_CYCLES, PACE_CYCLES));

    logic [TW-1:0] wait_q;

    assign fire = run && (wait_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q <= '0;
        end else if (start) begin
            wait_q <= TW'(LEAD_CYCLES - 1);
        end else if (run) begin
            if (wait_q == '0) wait_q <= TW'(PACE_CYCLES - 1);
            else              wait_q <= wait_q - 1'b1;
        end
    end

    // R4
    lead_gap_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> !fire);

    // R5
    pace_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !start) |=> !fire);

endmodule

// File: rtl/sdma_counters.sv
module sdma_counters
    import sdma_pkg::*;
#(
    parameter int XFER_LEN = 160,
    localparam int OFF_W   = span_bits(XFER_LEN),
    localparam int CNT_W   = $clog2(XFER_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  sdma_cmd_t         cmd,
    input  logic              fire,
    output logic [ADDR_W-1:0] src_q,
    output logic [OFF_W-1:0]  off_q,
    output logic              busy,
    output logic              done
);

    logic [CNT_W-1:0] left_q;

    assign busy = (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            off_q  <= '0;
            left_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= fire && (left_q == CNT_W'(1)) && !cmd.go;
            if (cmd.go) begin
                src_q  <= cmd.base;
                off_q  <= '0;
                left_q <= CNT_W'(XFER_LEN);
            end else if (fire) begin
                src_q  <= src_q + 1'b1;
                off_q  <= off_q + 1'b1;
                left_q <= left_q - 1'b1;
            end
        end
    end

    // R2
    load_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.go |=> (busy && src_q == $past(cmd.base) && off_q == '0));

    // R6
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !cmd.go) |=> (src_q == $past(src_q) + 1'b1));

    // R7
    offset_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (int'(off_q) < XFER_LEN));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/sprite_dma.sv
module sprite_dma
    import sdma_pkg::*;
#(
    parameter int                XFER_LEN    = 160,
    parameter int                LEAD_CYCLES = 8,
    parameter int                PACE_CYCLES = 4,
    parameter logic [ADDR_W-1:0] BASE_LIMIT  = 16'hF100,
    parameter int                DATA_W      = 8,
    localparam int               OFF_W       = span_bits(XFER_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_valid,
    input  logic [ADDR_W-1:0] trig_base,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              attr_we,
    output logic [OFF_W-1:0]  attr_addr,
    output logic [DATA_W-1:0] attr_wdata,
    output logic              busy,
    output logic [ADDR_W-1:0] src_addr,
    output logic              done
);

    sdma_cmd_t         cmd;
    logic              fire;
    logic [ADDR_W-1:0] src_q;
    logic [OFF_W-1:0]  off_q;

    sdma_trig_decode #(
        .BASE_LIMIT(BASE_LIMIT)
    ) u_decode (
        .trig_valid(trig_valid),
        .trig_base (trig_base),
        .cmd       (cmd)
    );

    sdma_pacer #(
        .LEAD_CYCLES(LEAD_CYCLES),
        .PACE_CYCLES(PACE_CYCLES)
    ) u_pacer (
        .clk  (clk),
        .rst  (rst),
        .start(cmd.go),
        .run  (busy),
        .fire (fire)
    );

    sdma_counters #(
        .XFER_LEN(XFER_LEN)
    ) u_count (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .fire (fire),
        .src_q(src_q),
        .off_q(off_q),
        .busy (busy),
        .done (done)
    );

    assign rd_req     = fire;
    assign rd_addr    = src_q;
    assign attr_we    = fire;
    assign attr_addr  = off_q;
    assign attr_wdata = rd_data;
    assign src_addr   = src_q;

    // R3
    ignore_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_valid && trig_base > BASE_LIMIT && !busy) |=> !busy);

    // R3
    ignore_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_valid && trig_base > BASE_LIMIT && busy && !attr_we)
            |=> (src_addr == $past(src_addr)));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !attr_we);

endmodule

// File: tb/sprite_dma_tb.sv
module sprite_dma_tb;

    localparam int LEN   = 160;
    localparam int LEAD  = 8;
    localparam int PACE  = 4;
    localparam int LIMIT = 16'hF100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig_valid = 1'b0;
    logic [15:0] trig_base = '0;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic [7:0]  rd_data;
    logic        attr_we;
    logic [7:0]  attr_addr;
    logic [7:0]  attr_wdata;
    logic        busy;
    logic [15:0] src_addr;
    logic        done;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign rd_data = pat(rd_addr);

    sprite_dma u_dut (
        .clk(clk), .rst(rst), .trig_valid(trig_valid), .trig_base(trig_base),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .attr_we(attr_we), .attr_addr(attr_addr), .attr_wdata(attr_wdata),
        .busy(busy), .src_addr(src_addr), .done(done)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: schedule arithmetic on edge numbers
    int  edges = 0;
    always @(posedge clk) edges++;

    bit  m_on = 0, m_active = 0, m_done = 0;
    int  m_base = 0, m_idx = 0, m_start = 0;
    int  done_cnt = 0, wr_cnt = 0;
    logic [7:0] shadow [LEN];

    always @(negedge clk) begin
        int d;
        bit exp_we, nd;
        d = (edges + 1) - m_start;
        exp_we = m_active && d >= LEAD && ((d - LEAD) % PACE) == 0;
        if (m_on) begin
            chk("R7", "busy", busy, m_active);
            chk("R8", "done", done, m_done);
            chk("R2", "src_addr", src_addr, (m_base + m_idx) & 16'hFFFF);
            chk("R4 R5", "strobe", attr_we, exp_we);
            chk("R5", "rd_req", rd_req, exp_we);
            if (exp_we) begin
                chk("R6", "rd_addr", rd_addr, (m_base + m_idx) & 16'hFFFF);
                chk("R6", "attr_addr", attr_addr, m_idx);
                chk("R6", "attr_wdata", attr_wdata, rd_data);
            end
            if (attr_we) begin
                shadow[attr_addr] = attr_wdata;
                wr_cnt++;
            end
            if (done) done_cnt++;
        end
        nd = 0;
        if (rst) begin
            m_active = 0; m_base = 0; m_idx = 0; m_on = 1;
        end else begin
            if (exp_we) begin
                m_idx++;
                if (m_idx == LEN) begin m_active = 0; nd = 1; end
            end
            if (trig_valid && trig_base <= LIMIT) begin
                m_active = 1; m_base = trig_base; m_idx = 0;
                m_start = edges + 1; nd = 0;
            end
        end
        m_done = nd;
    end

    task automatic fire_trig(input logic [15:0] b);
        @(posedge clk); #1;
        trig_valid = 1'b1; trig_base = b;
        @(posedge clk); #1;
        trig_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_shadow(input string req, input logic [15:0] b);
        int bad;
        bad = 0;
        for (int i = 0; i < LEN; i++)
            if (shadow[i] !== pat(b + 16'(i))) bad++;
        chk(req, "attribute image mismatches", bad, 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "done after reset", done, 0);
        chk("R1", "src_addr after reset", src_addr, 0);
        chk("R1", "attr_we after reset", attr_we, 0);

        // R2 R4 R5 R6 R7 R8: plain copy
        done_cnt = 0; wr_cnt = 0;
        fire_trig(16'hC000);
        @(negedge clk);
        chk("R2", "busy after trigger", busy, 1);
        wait_idle();
        chk("R7", "bytes written", wr_cnt, LEN);
        chk("R8", "done pulses", done_cnt, 1);
        check_shadow("R6", 16'hC000);

        // R3: out-of-range triggers while idle
        fire_trig(16'hF101);
        @(negedge clk);
        chk("R3", "busy after F101", busy, 0);
        chk("R3", "src_addr after F101", src_addr, 16'hC0A0);
        fire_trig(16'hFFFF);
        @(negedge clk);
        chk("R3", "busy after FFFF", busy, 0);

        // R3: boundary accepted, and an ignored trigger while busy
        done_cnt = 0; wr_cnt = 0;
        fire_trig(16'hF100);
        repeat (50) @(posedge clk);
        fire_trig(16'hFE00);
        wait_idle();
        chk("R3", "bytes from F100", wr_cnt, LEN);
        chk("R3", "done from F100", done_cnt, 1);
        check_shadow("R3", 16'hF100);

        // R9: restarts at every phase of the pacing
        for (int k = 0; k < 12; k++) begin
            done_cnt = 0;
            fire_trig(16'h8000 + 16'(k * 16'h0100));
            repeat (20 + k) @(posedge clk);
            fire_trig(16'h1234 + 16'(k));
            wait_idle();
            chk("R9", "done after restart", done_cnt, 1);
            check_shadow("R9", 16'h1234 + 16'(k));
        end

        // R9: back-to-back triggers
        done_cnt = 0;
        @(posedge clk); #1;
        trig_valid = 1'b1; trig_base = 16'h4000;
        @(posedge clk); #1;
        trig_base = 16'h0000;
        @(posedge clk); #1;
        trig_valid = 1'b0;
        wait_idle();
        chk("R9", "done after back-to-back", done_cnt, 1);
        check_shadow("R9", 16'h0000);

        // R1: reset in mid-copy
        fire_trig(16'h2000);
        repeat (30) @(posedge clk);
        #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk("R1", "busy after mid reset", busy, 0);
        chk("R1", "src_addr after mid reset", src_addr, 0);

        finish_run();
    end

endmodule